// File: doc/BRIEF.md
# Serial Chain Reader Controller

This block is the master side of a link to an external chain of parallel-in, serial-out shift registers. When a start request arrives, it holds the chain's shift clock low. It drives an active-low load strobe low for a set number of system cycles to capture the parallel inputs, and then releases the strobe. The strobe stays high for the rest of the frame, so the captured data cannot change.

After that, the block reads the serial data line once per bit. Each bit is sampled before the clock edge that would move it out of the chain, so the bit nearest the output is never lost. After every sample the block raises and then lowers the shift clock. Received bits are packed into bytes: each sample enters the top of a byte register that shifts right, and each finished byte goes to the next slot of the frame output. The chain is loaded once per frame, and the bit count runs on across byte boundaries, so a cascaded chain of any number of bytes is read in one pass.

An optional extra bit can be read after the last clock pulse. This is the value that the chain's serial input has pushed to its output. It is sampled after one more clock-low phase and no further clock edge is issued. Every pin width is set in system-clock cycles by a parameter.

Top module: `sreg_chain_reader`

## Requirements
- R1: While reset is applied and after it is released, with no start request, busy_o and done_o are 0, chain_sck_o is 0 and chain_load_no is 1.
- R2: A start request seen while idle drives chain_load_no low for exactly LOAD_LOW_CYC consecutive cycles, and only while busy_o is 1.
- R3: chain_sck_o is 0 whenever chain_load_no is 0. chain_load_no goes low only once per frame and stays high from its release to the end of the frame, so parallel inputs that change after the load do not affect the result.
- R4: Bit ordering: the n-th bit read from the data line (n counted from 0, with the first read before any shift clock rising edge) appears at frame_o[n]. So byte k of the frame is frame_o[8k+7:8k], and its first received bit is in its bit 0.
- R5: Each shift clock high phase lasts CLK_HIGH_CYC cycles, each data sample ends a low phase of CLK_LOW_CYC cycles, and a frame has exactly NUM_BYTES*8 rising edges of chain_sck_o.
- R6: With EXTRA_BIT_EN=1, one more low phase follows the last clock pulse. At its end the data line is captured into extra_o with no further rising edge. extra_o changes only in the cycle done_o is high.
- R7: done_o is high for exactly one cycle, in the cycle right after the last busy cycle. A frame is busy for LOAD_LOW_CYC + NUM_BYTES*8*(CLK_LOW_CYC+CLK_HIGH_CYC) cycles, plus CLK_LOW_CYC when EXTRA_BIT_EN=1.
- R8: A start request while busy_o is 1 is ignored: the frame keeps its length, its single load pulse and its result.
- R9: With EXTRA_BIT_EN=0, extra_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Frame request, taken only while idle |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when the frame is stored |
| frame_o | output | NUM_BYTES*8 | Received bytes; byte k at bits 8k+7..8k |
| extra_o | output | 1 | Extra bit read after the final clock pulse |
| chain_sck_o | output | 1 | Shift clock to the chain |
| chain_load_no | output | 1 | Active-low parallel load strobe to the chain |
| chain_dat_i | input | 1 | Serial data from the far end of the chain |

## Verification
The bench builds two instances. The first has two bytes, the extra bit on, a two-cycle load, a one-cycle clock-high phase and a two-cycle clock-low phase. With these settings it exercises the byte-boundary carry of the bit count, the order of the two stored slots, the extra-bit capture with no added edge, and unequal high and low widths. The second has one byte, no extra bit and one-cycle phases everywhere. This covers the shortest timing the chain model has to follow and checks that extra_o stays at zero. On the first instance, a start request issued mid-frame together with a parallel-input change shows that neither the repeated request nor late input data has any effect.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } scr_state_e;
endpackage

// File: rtl/scr_rst_sync.sv
module scr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/scr_phase_timer.sv
module scr_phase_timer #(
  parameter int unsigned TMR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/scr_byte_store.sv
module scr_byte_store #(
  parameter int unsigned NUM_BYTES = 2,
  parameter int unsigned IDX_W     = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic [IDX_W-1:0]       sel_i,
  input  logic                   bit_i,
  output logic [NUM_BYTES*8-1:0] data_o
);
  import scr_pkg::*;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
    logic [BYTE_W-1:0] slot_q, slot_d;
    logic              wr_en;

    assign wr_en = shift_i && (sel_i == IDX_W'(k));

    always_comb begin
      slot_d = slot_q;
      if (wr_en) slot_d = {bit_i, slot_q[BYTE_W-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else         slot_q <= slot_d;
    end

    assign data_o[k*BYTE_W +: BYTE_W] = slot_q;
  end
endmodule

// File: rtl/sreg_chain_reader.sv
module sreg_chain_reader #(
  parameter int unsigned NUM_BYTES    = 2,
  parameter bit          EXTRA_BIT_EN = 1'b1,
  parameter int unsigned LOAD_LOW_CYC = 2,
  parameter int unsigned CLK_HIGH_CYC = 2,
  parameter int unsigned CLK_LOW_CYC  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NUM_BYTES*8-1:0] frame_o,
  output logic                   extra_o,
  output logic                   chain_sck_o,
  output logic                   chain_load_no,
  input  logic                   chain_dat_i
);
  import scr_pkg::*;

  localparam int unsigned TOTAL_BITS = NUM_BYTES * BYTE_W;
  localparam int unsigned CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam int unsigned MAX_A      = (LOAD_LOW_CYC > CLK_HIGH_CYC) ? LOAD_LOW_CYC : CLK_HIGH_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > CLK_LOW_CYC) ? MAX_A : CLK_LOW_CYC;
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);
  localparam int unsigned IDX_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic             rst_n_sync;
  scr_state_e       state_q, state_d;
  logic [CNT_W-1:0] bits_left_q, bits_left_d;
  logic [CNT_W-1:0] bits_done;
  logic             extra_q, extra_d;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             shift_en;
  logic [IDX_W-1:0] byte_sel;

  scr_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  scr_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  assign bits_done = CNT_W'(TOTAL_BITS) - bits_left_q;
  assign byte_sel  = IDX_W'(bits_done >> 3);

  scr_byte_store #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .shift_i (shift_en),
    .sel_i   (byte_sel),
    .bit_i   (chain_dat_i),
    .data_o  (frame_o)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    bits_left_d = bits_left_q;
    extra_d     = extra_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    shift_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d     = ST_LOAD;
          tmr_load    = 1'b1;
          tmr_val     = TMR_W'(LOAD_LOW_CYC - 1);
          bits_left_d = CNT_W'(TOTAL_BITS);
        end
      end
      ST_LOAD: begin
        if (tmr_exp) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CLK_LOW_CYC - 1);
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          if (bits_left_q != '0) begin
            shift_en = 1'b1;
            state_d  = ST_HIGH;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(CLK_HIGH_CYC - 1);
          end else begin
            if (EXTRA_BIT_EN) extra_d = chain_dat_i;
            state_d = ST_DONE;
          end
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          bits_left_d = bits_left_q - CNT_W'(1);
          if ((bits_left_q == CNT_W'(1)) && !EXTRA_BIT_EN) begin
            state_d = ST_DONE;
          end else begin
            state_d  = ST_LOW;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(CLK_LOW_CYC - 1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q     <= ST_IDLE;
      bits_left_q <= '0;
      extra_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      bits_left_q <= bits_left_d;
      extra_q     <= extra_d;
    end
  end

  assign busy_o        = (state_q == ST_LOAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign done_o        = (state_q == ST_DONE);
  assign chain_sck_o   = (state_q == ST_HIGH);
  assign chain_load_no = (state_q != ST_LOAD);
  assign extra_o       = extra_q;
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter bit EXTRA_BIT_EN = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic extra_o,
  input logic chain_sck_o,
  input logic chain_load_no
);
  AST_LOAD_KEEPS_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_load_no |-> !chain_sck_o);  // R3

  AST_LOAD_INSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_load_no |-> busy_o);  // R2

  AST_LOAD_FROM_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chain_load_no) |-> ($past(!busy_o) && $past(start_i)));  // R8

  AST_NO_RELOAD_AFTER_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_sck_o |=> chain_load_no);  // R3

  AST_SCK_INSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_sck_o |-> busy_o);  // R5

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));  // R7

  AST_EXTRA_MOVES_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(extra_o) |-> done_o);  // R6

  if (!EXTRA_BIT_EN) begin : g_no_extra
    AST_EXTRA_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !extra_o);  // R9
  end
endmodule

bind sreg_chain_reader scr_checker #(.EXTRA_BIT_EN(EXTRA_BIT_EN)) u_checker (.*);

// File: tb/sreg_chain_reader_tb_top.sv
`timescale 1ns/1ps

module scr_chain_model #(
  parameter int unsigned BITS = 16
) (
  input  logic            clk,
  input  logic            sck,
  input  logic            load_n,
  input  logic [BITS-1:0] par,
  input  logic            ser,
  output logic            dat
);
  logic [BITS-1:0] sh;
  logic            sck_d;

  always @(posedge clk) begin
    sck_d <= sck;
    if (!load_n)            sh <= par;
    else if (sck && !sck_d) sh <= {ser, sh[BITS-1:1]};
  end

  assign dat = sh[0];
endmodule

module sreg_chain_reader_tb_top;
  localparam int NV = 6;
  // {serial-in, parallel word}
  localparam logic [16:0] VEC [NV] = '{
    17'h1_0000, 17'h0_FFFF, 17'h1_A55A, 17'h0_0180, 17'h1_8001, 17'h0_1234
  };
  localparam int LEN_A = 2 + 16 * (2 + 1) + 2;
  localparam int LEN_B = 1 + 8 * (1 + 1);

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        start  [2];
  logic        busy   [2];
  logic        done   [2];
  logic        extra  [2];
  logic        sck    [2];
  logic        load_n [2];
  logic        dat    [2];
  logic [15:0] frame  [2];
  logic [15:0] par    [2];
  logic        ser    [2];
  logic [7:0]  frame_b;

  sreg_chain_reader #(.NUM_BYTES(2), .EXTRA_BIT_EN(1'b1), .LOAD_LOW_CYC(2),
                      .CLK_HIGH_CYC(1), .CLK_LOW_CYC(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[0]), .busy_o(busy[0]),
    .done_o(done[0]), .frame_o(frame[0]), .extra_o(extra[0]),
    .chain_sck_o(sck[0]), .chain_load_no(load_n[0]), .chain_dat_i(dat[0]));

  sreg_chain_reader #(.NUM_BYTES(1), .EXTRA_BIT_EN(1'b0), .LOAD_LOW_CYC(1),
                      .CLK_HIGH_CYC(1), .CLK_LOW_CYC(1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[1]), .busy_o(busy[1]),
    .done_o(done[1]), .frame_o(frame_b), .extra_o(extra[1]),
    .chain_sck_o(sck[1]), .chain_load_no(load_n[1]), .chain_dat_i(dat[1]));
  assign frame[1] = {8'h00, frame_b};

  scr_chain_model #(.BITS(16)) chain_a (.clk(clk), .sck(sck[0]), .load_n(load_n[0]),
                                        .par(par[0]), .ser(ser[0]), .dat(dat[0]));
  scr_chain_model #(.BITS(8)) chain_b (.clk(clk), .sck(sck[1]), .load_n(load_n[1]),
                                       .par(par[1][7:0]), .ser(ser[1]), .dat(dat[1]));

  int total = 0;
  int bad   = 0;
  int busy_cnt [2], load_cnt [2], load_fall [2], rise_cnt [2];
  int hi_run [2], hi_min [2], hi_max [2];
  logic sck_p [2], load_p [2];

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (busy[i]) busy_cnt[i]++;
      if (!load_n[i]) load_cnt[i]++;
      if (!load_n[i] && load_p[i]) load_fall[i]++;
      if (sck[i] && !sck_p[i]) rise_cnt[i]++;
      if (sck[i]) hi_run[i]++;
      else if (hi_run[i] != 0) begin
        if (hi_run[i] < hi_min[i]) hi_min[i] = hi_run[i];
        if (hi_run[i] > hi_max[i]) hi_max[i] = hi_run[i];
        hi_run[i] = 0;
      end
      sck_p[i]  = sck[i];
      load_p[i] = load_n[i];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon(input int i);
    busy_cnt[i] = 0; load_cnt[i] = 0; load_fall[i] = 0; rise_cnt[i] = 0;
    hi_run[i] = 0; hi_min[i] = 1000; hi_max[i] = 0;
  endtask

  task automatic run_frame(input int i, input logic [15:0] p, input logic s, input bit disturb);
    int  len;
    int  n;
    bit  seen;
    len = (i == 0) ? LEN_A : LEN_B;
    @(posedge clk); #1;
    par[i] = p; ser[i] = s;
    clear_mon(i);
    start[i] = 1'b1;
    @(posedge clk); #1;
    start[i] = 1'b0;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 400) begin
      @(negedge clk);
      n++;
      if (disturb && n == 12) begin
        #0.5;
        start[i] = 1'b1;
        par[i]   = ~p;
      end
      if (disturb && n == 13) start[i] = 1'b0;
      if (done[i]) seen = 1'b1;
    end
    check("R7", "done seen", int'(seen), 1);
    if (i == 0) check("R4", "frame A", int'(frame[0]), int'(p));
    else        check("R4", "frame B", int'(frame[1]), int'(p[7:0]));
    if (i == 0) check("R6", "extra bit", int'(extra[0]), int'(s));
    else        check("R9", "extra stays 0", int'(extra[1]), 0);
    check("R7", "busy length", busy_cnt[i], len);
    check("R2", "load low width", load_cnt[i], (i == 0) ? 2 : 1);
    check("R3", "load pulses per frame", load_fall[i], 1);
    check("R5", "rising edges", rise_cnt[i], (i == 0) ? 16 : 8);
    check("R5", "high width min", hi_min[i], 1);
    check("R5", "high width max", hi_max[i], 1);
    if (disturb) check("R8", "busy after mid start", int'(busy[i]), 0);
    @(negedge clk);
    check("R7", "done one cycle", int'(done[i]), 0);
    check("R7", "idle after done", int'(busy[i]), 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      start[i] = 1'b0; par[i] = '0; ser[i] = 1'b0;
      sck_p[i] = 1'b0; load_p[i] = 1'b1;
      clear_mon(i);
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("R1", "busy in reset", int'(busy[i]), 0);
      check("R1", "load_n in reset", int'(load_n[i]), 1);
    end
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("R1", "busy idle", int'(busy[i]), 0);
      check("R1", "done idle", int'(done[i]), 0);
      check("R1", "sck idle", int'(sck[i]), 0);
      check("R1", "load_n idle", int'(load_n[i]), 1);
    end

    for (int v = 0; v < NV; v++) begin
      run_frame(0, VEC[v][15:0], VEC[v][16], 1'b0);
      run_frame(1, VEC[v][15:0], VEC[v][16], 1'b0);
    end

    // R8 and R3: mid-frame start request and parallel change are ignored
    run_frame(0, 16'h3C96, 1'b1, 1'b1);
    run_frame(1, 16'h00C3, 1'b0, 1'b1);
    // back-to-back frames keep working after an ignored request
    run_frame(0, 16'h7E01, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule